// File: doc/BRIEF.md
# Multidrop UART Receive Address Filter

This block sits between a UART receiver that produces 9-bit characters and the receive data register of a node on a shared multi-node serial bus. Each character arrives with a one-cycle valid strobe, an 8-bit payload, a flag that marks it as an address character, and a framing-error flag. From a multiprocessor enable bit, a 2-bit policy field and an 8-bit own-address value, the filter decides whether the character is delivered and whether it raises a receive interrupt. Delivered characters carry two status bits. One tells whether the character was an address. The other marks the first data character of a frame the node has accepted.

The four policies range from software-assisted to fully hardware-matched. In policy 00b every character interrupts. In policy 01b only address characters interrupt, so software can inspect them and then fall back to 00b. In policies 10b and 11b a hardware comparator tracks frame membership. Characters of frames addressed to other nodes never reach software. Policy 11b also keeps matched address characters out of the data path.

The match tracker is a three-state machine:
- `ST_HUNT`: no accepted frame.
- `ST_ARMED`: a matching address was seen and no data has followed yet.
- `ST_IN_FRAME`: at least one data character of the accepted frame has been delivered.

Its transitions are:
- `T_HIT`: a good address equals the own address, so the machine goes to `ST_ARMED` from any state.
- `T_MISS`: a good address differs from the own address, so the machine goes to `ST_HUNT` from any state.
- `T_FIRST`: a good data character arrives in `ST_ARMED`, so the machine goes to `ST_IN_FRAME`.
- `T_STAY`: a good data character arrives in `ST_IN_FRAME` or `ST_HUNT`, and the state is kept.
- `T_CLEAR`: a policy write, or any cycle in which hardware matching is off, forces the machine to `ST_HUNT`.

Top module: `mar_rx_addr_filter`

## Requirements
- R1: After reset `out_valid`, `out_irq`, `out_addr_flag` and `out_new_frame` are 0 and the match tracker is in `ST_HUNT`.
- R2: With `mp_enable`=0, every character without a framing error is delivered with an interrupt. `out_addr_flag` equals its address flag and `out_new_frame` is 0.
- R3: A character with `rx_frame_err`=1 is never delivered and never interrupts, in any policy. It leaves the match state unchanged.
- R4: With `mp_enable`=1 and `mp_mode`=00b, every good character is delivered with an interrupt and `out_new_frame`=0.
- R5: With `mp_enable`=1 and `mp_mode`=01b, every good character is delivered. Only address characters (`rx_is_addr`=1) interrupt.
- R6: In policy 10b, an address character whose data differs from `own_addr` is dropped. Every data character after it is dropped until a matching address arrives.
- R7: In policy 10b, a matching address character is delivered with `out_addr_flag`=1 and an interrupt. Each following good data character of that frame is delivered with an interrupt.
- R8: In policies 10b and 11b, the first data character delivered after a matching address has `out_new_frame`=1. Later data characters of the frame have it at 0.
- R9: Every address character is compared again. A match restarts the frame, so `out_new_frame` returns on its next data character. A mismatch suppresses all characters until a later match.
- R10: In policy 11b, address characters are never delivered and never interrupt. Data characters behave as in policy 10b.
- R11: A pulse on `mode_wr` returns the tracker to `ST_HUNT`. The tracker also stays in `ST_HUNT` while hardware matching is off (`mp_enable`=0 or `mp_mode[1]`=0).
- R12: Outputs are registered with one cycle of latency. `out_valid` is a single-cycle pulse for each delivered character, and `out_irq` is only ever high together with `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | One-cycle strobe for a received character |
| rx_data | input | DATA_W | Received payload |
| rx_is_addr | input | 1 | Ninth bit: 1 marks an address character |
| rx_frame_err | input | 1 | Stop bit of the character was missing |
| mp_enable | input | 1 | Turns multidrop filtering on |
| mp_mode | input | 2 | Filtering policy 00b/01b/10b/11b |
| mode_wr | input | 1 | Pulse when the policy field is written |
| own_addr | input | DATA_W | This node's address |
| out_valid | output | 1 | Delivered character strobe |
| out_data | output | DATA_W | Delivered payload |
| out_addr_flag | output | 1 | Delivered character was an address |
| out_new_frame | output | 1 | First data character of an accepted frame |
| out_irq | output | 1 | Receive interrupt pulse |

## Verification
The bench goes after frame boundaries in the hardware-matched policies. It sends back-to-back matching addresses, a mismatch in the middle of an accepted frame, and a framing-error data character inside a frame. A tracker that mishandled these would keep delivering foreign data, drop the new-frame flag on a restarted frame, or lose the frame after a corrupted character. It also writes the policy in the middle of a frame and sends address characters in policy 11b. A design that ignored the write would leak data after it. A design that treated 11b like 10b would present address characters to software. Random traffic uses a mix of own and foreign addresses under every policy, and each output is compared with a bench model of the requirements.

// File: rtl/mar_pkg.sv
package mar_pkg;

    typedef enum logic [1:0] {
        ST_HUNT     = 2'd0,
        ST_ARMED    = 2'd1,
        ST_IN_FRAME = 2'd2
    } mar_state_e;

    localparam logic [1:0] POL_ALL      = 2'b00;
    localparam logic [1:0] POL_ADDR_IRQ = 2'b01;
    localparam logic [1:0] POL_HW_MATCH = 2'b10;
    localparam logic [1:0] POL_HW_QUIET = 2'b11;

endpackage

// File: rtl/mar_addr_cmp.sv
module mar_addr_cmp #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] cand,
    input  logic [DATA_W-1:0] own,
    output logic              hit
);
    logic [DATA_W-1:0] bit_eq;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign bit_eq[i] = ~(cand[i] ^ own[i]);
    end

    assign hit = &bit_eq;
endmodule

// File: rtl/mar_match_fsm.sv
module mar_match_fsm
    import mar_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       char_ok,
    input  logic       is_addr,
    input  logic       addr_hit,
    output mar_state_e state
);
    mar_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (clear) begin
            state_d = ST_HUNT;                       // T_CLEAR
        end else if (char_ok) begin
            if (is_addr) begin
                state_d = addr_hit ? ST_ARMED : ST_HUNT; // T_HIT / T_MISS
            end else begin
                unique case (state_q)
                    ST_ARMED:    state_d = ST_IN_FRAME;  // T_FIRST
                    ST_IN_FRAME: state_d = ST_IN_FRAME;  // T_STAY
                    ST_HUNT:     state_d = ST_HUNT;      // T_STAY
                    default:     state_d = ST_HUNT;
                endcase
            end
        end
    end

    assign state = state_q;
endmodule

// File: rtl/mar_decide.sv
module mar_decide
    import mar_pkg::*;
(
    input  logic       rx_valid,
    input  logic       rx_is_addr,
    input  logic       rx_frame_err,
    input  logic       mp_enable,
    input  logic [1:0] mp_mode,
    input  mar_state_e state,
    input  logic       addr_hit,
    output logic       deliver,
    output logic       irq,
    output logic       new_frame
);
    logic char_ok;
    logic in_match;

    assign char_ok  = rx_valid & ~rx_frame_err;
    assign in_match = (state != ST_HUNT);

    always_comb begin
        deliver   = 1'b0;
        irq       = 1'b0;
        new_frame = 1'b0;
        if (char_ok) begin
            if (!mp_enable) begin
                deliver = 1'b1;
                irq     = 1'b1;
            end else begin
                unique case (mp_mode)
                    POL_ALL: begin
                        deliver = 1'b1;
                        irq     = 1'b1;
                    end
                    POL_ADDR_IRQ: begin
                        deliver = 1'b1;
                        irq     = rx_is_addr;
                    end
                    POL_HW_MATCH: begin
                        if (rx_is_addr) begin
                            deliver = addr_hit;
                            irq     = addr_hit;
                        end else begin
                            deliver   = in_match;
                            irq       = in_match;
                            new_frame = (state == ST_ARMED);
                        end
                    end
                    POL_HW_QUIET: begin
                        if (!rx_is_addr) begin
                            deliver   = in_match;
                            irq       = in_match;
                            new_frame = (state == ST_ARMED);
                        end
                    end
                    default: begin
                        deliver = 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/mar_out_stage.sv
module mar_out_stage #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              deliver,
    input  logic              irq,
    input  logic              new_frame,
    input  logic              is_addr,
    input  logic [DATA_W-1:0] data,
    output logic              out_valid,
    output logic              out_irq,
    output logic              out_new_frame,
    output logic              out_addr_flag,
    output logic [DATA_W-1:0] out_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_irq       <= 1'b0;
            out_new_frame <= 1'b0;
            out_addr_flag <= 1'b0;
            out_data      <= '0;
        end else begin
            out_valid     <= deliver;
            out_irq       <= deliver & irq;
            out_new_frame <= deliver & new_frame;
            out_addr_flag <= deliver & is_addr;
            if (deliver) begin
                out_data <= data;
            end
        end
    end
endmodule

// File: rtl/mar_rx_addr_filter.sv
module mar_rx_addr_filter
    import mar_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_is_addr,
    input  logic              rx_frame_err,
    input  logic              mp_enable,
    input  logic [1:0]        mp_mode,
    input  logic              mode_wr,
    input  logic [DATA_W-1:0] own_addr,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_addr_flag,
    output logic              out_new_frame,
    output logic              out_irq
);
    logic       addr_hit;
    logic       hw_match;
    logic       tracker_clear;
    logic       char_ok;
    logic       deliver;
    logic       irq_d;
    logic       nf_d;
    mar_state_e match_state;

    assign hw_match      = mp_enable & mp_mode[1];
    assign tracker_clear = mode_wr | ~hw_match;
    assign char_ok       = rx_valid & ~rx_frame_err;

    mar_addr_cmp #(.DATA_W(DATA_W)) u_cmp (
        .cand (rx_data),
        .own  (own_addr),
        .hit  (addr_hit)
    );

    mar_match_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (tracker_clear),
        .char_ok  (char_ok),
        .is_addr  (rx_is_addr),
        .addr_hit (addr_hit),
        .state    (match_state)
    );

    mar_decide u_dec (
        .rx_valid     (rx_valid),
        .rx_is_addr   (rx_is_addr),
        .rx_frame_err (rx_frame_err),
        .mp_enable    (mp_enable),
        .mp_mode      (mp_mode),
        .state        (match_state),
        .addr_hit     (addr_hit),
        .deliver      (deliver),
        .irq          (irq_d),
        .new_frame    (nf_d)
    );

    mar_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk           (clk),
        .rst_n         (rst_n),
        .deliver       (deliver),
        .irq           (irq_d),
        .new_frame     (nf_d),
        .is_addr       (rx_is_addr),
        .data          (rx_data),
        .out_valid     (out_valid),
        .out_irq       (out_irq),
        .out_new_frame (out_new_frame),
        .out_addr_flag (out_addr_flag),
        .out_data      (out_data)
    );
endmodule

// File: rtl/mar_filter_checker.sv
module mar_filter_checker
    import mar_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic       rx_is_addr,
    input logic       rx_frame_err,
    input logic       mp_enable,
    input logic [1:0] mp_mode,
    input logic       mode_wr,
    input mar_state_e match_state,
    input logic       out_valid,
    input logic       out_addr_flag,
    input logic       out_new_frame,
    input logic       out_irq
);
    // R12: an interrupt never comes without a delivered character
    a_r12_irq_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_irq |-> out_valid);

    // R12: no strobe in, no strobe out on the next cycle
    a_r12_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> !out_valid);

    // R3: framing-error characters are dropped
    a_r3_ferr_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_frame_err) |=> !out_valid);

    // R3: framing-error characters leave the tracker alone
    a_r3_ferr_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_frame_err && !mode_wr && mp_enable && mp_mode[1])
        |=> (match_state == $past(match_state)));

    // R2: filtering off delivers every good character with an interrupt
    a_r2_disabled_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_frame_err && !mp_enable) |=> (out_valid && out_irq));

    // R8: new-frame marks data characters only
    a_r8_nf_on_data: assert property (@(posedge clk) disable iff (!rst_n)
        out_new_frame |-> (out_valid && !out_addr_flag));

    // R6: data in the hunt state is dropped under hardware matching
    a_r6_hunt_drops_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_is_addr && mp_enable && mp_mode[1] && match_state == ST_HUNT)
        |=> !out_valid);

    // R10: quiet policy never presents address characters
    a_r10_quiet_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_is_addr && mp_enable && mp_mode == POL_HW_QUIET) |=> !out_valid);

    // R11: policy write resets the tracker
    a_r11_clear_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (match_state == ST_HUNT));

    // R11: tracker idle while hardware matching is off
    a_r11_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !(mp_enable && mp_mode[1]) |=> (match_state == ST_HUNT));
endmodule

bind mar_rx_addr_filter mar_filter_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_valid      (rx_valid),
    .rx_is_addr    (rx_is_addr),
    .rx_frame_err  (rx_frame_err),
    .mp_enable     (mp_enable),
    .mp_mode       (mp_mode),
    .mode_wr       (mode_wr),
    .match_state   (match_state),
    .out_valid     (out_valid),
    .out_addr_flag (out_addr_flag),
    .out_new_frame (out_new_frame),
    .out_irq       (out_irq)
);

// File: tb/tb_mar_rx_addr_filter.sv
`timescale 1ns/1ps
module tb_mar_rx_addr_filter;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rx_valid = 1'b0;
    logic [DATA_W-1:0] rx_data = '0;
    logic              rx_is_addr = 1'b0;
    logic              rx_frame_err = 1'b0;
    logic              mp_enable = 1'b0;
    logic [1:0]        mp_mode = 2'b00;
    logic              mode_wr = 1'b0;
    logic [DATA_W-1:0] own_addr = 8'h5A;
    logic              out_valid;
    logic [DATA_W-1:0] out_data;
    logic              out_addr_flag;
    logic              out_new_frame;
    logic              out_irq;

    int checks = 0;
    int errors = 0;
    int mstate = 0; // bench model: 0 hunt, 1 armed, 2 in frame
    logic [DATA_W-1:0] last_data = '0;

    always #2.5 clk = ~clk;

    mar_rx_addr_filter #(.DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_is_addr(rx_is_addr), .rx_frame_err(rx_frame_err),
        .mp_enable(mp_enable), .mp_mode(mp_mode), .mode_wr(mode_wr),
        .own_addr(own_addr), .out_valid(out_valid), .out_data(out_data),
        .out_addr_flag(out_addr_flag), .out_new_frame(out_new_frame),
        .out_irq(out_irq)
    );

    // expected {valid, addr_flag, new_frame, irq}
    function automatic logic [3:0] model_out(input logic en, input logic [1:0] md,
                                             input int st, input logic isa,
                                             input logic fe, input logic hit);
        logic v, ir, nf;
        v = 0; ir = 0; nf = 0;
        if (!fe) begin
            if (!en)             begin v = 1; ir = 1; end
            else if (md == 2'b00) begin v = 1; ir = 1; end
            else if (md == 2'b01) begin v = 1; ir = isa; end
            else if (isa)        begin v = (md == 2'b10) && hit; ir = v; end
            else                 begin v = (st != 0); ir = v; nf = (st == 1); end
        end
        return {v, v & isa, nf, ir};
    endfunction

    function automatic int model_next(input logic en, input logic [1:0] md, input int st,
                                      input logic isa, input logic fe, input logic hit);
        if (!(en && md[1])) return 0;
        if (fe) return st;
        if (isa) return hit ? 1 : 0;
        if (st == 1) return 2;
        return st;
    endfunction

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp,
                         input logic [DATA_W-1:0] gd, input logic [DATA_W-1:0] ed);
        checks++;
        if (got !== exp || (exp[3] && gd !== ed)) begin
            errors++;
            $display("FAIL %s: got v/a/nf/irq=%b data=%h expected %b data=%h",
                     req, got, gd, exp, ed);
        end
    endtask

    task automatic set_mode(input logic en, input logic [1:0] md);
        @(negedge clk);
        mp_enable = en; mp_mode = md; mode_wr = 1'b1;
        @(negedge clk);
        mode_wr = 1'b0;
        mstate = 0;
    endtask

    task automatic send(input string req, input logic isa, input logic fe,
                        input logic [DATA_W-1:0] d);
        logic [3:0] exp;
        logic hit;
        hit = (d == own_addr);
        exp = model_out(mp_enable, mp_mode, mstate, isa, fe, hit);
        mstate = model_next(mp_enable, mp_mode, mstate, isa, fe, hit);
        @(negedge clk);
        rx_valid = 1'b1; rx_is_addr = isa; rx_frame_err = fe; rx_data = d;
        @(negedge clk);
        rx_valid = 1'b0;
        check(req, {out_valid, out_addr_flag, out_new_frame, out_irq}, exp, out_data, d);
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {out_valid, out_addr_flag, out_new_frame, out_irq}, 4'b0000, out_data, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {out_valid, out_addr_flag, out_new_frame, out_irq}, 4'b0000, out_data, '0);

        // R2: filtering off
        send("R2", 1'b0, 1'b0, 8'h11);
        send("R2", 1'b1, 1'b0, 8'h22);
        send("R3", 1'b0, 1'b1, 8'h33);
        // R4
        set_mode(1'b1, 2'b00);
        send("R4", 1'b1, 1'b0, 8'h01);
        send("R4", 1'b0, 1'b0, 8'h02);
        // R5
        set_mode(1'b1, 2'b01);
        send("R5", 1'b1, 1'b0, 8'h77);
        send("R5", 1'b0, 1'b0, 8'h44);
        // R6 / R7 / R8 / R3
        set_mode(1'b1, 2'b10);
        send("R6", 1'b1, 1'b0, 8'h12);
        send("R6", 1'b0, 1'b0, 8'h13);
        send("R7", 1'b1, 1'b0, 8'h5A);
        send("R8", 1'b0, 1'b0, 8'hA1);
        send("R8", 1'b0, 1'b0, 8'hA2);
        send("R3", 1'b0, 1'b1, 8'hA3);
        send("R3", 1'b0, 1'b0, 8'hA4);
        send("R3", 1'b1, 1'b1, 8'h99);
        send("R3", 1'b0, 1'b0, 8'hA5);
        // R9: restart then mismatch
        send("R9", 1'b1, 1'b0, 8'h5A);
        send("R9", 1'b1, 1'b0, 8'h5A);
        send("R9", 1'b0, 1'b0, 8'hB1);
        send("R9", 1'b1, 1'b0, 8'h5B);
        send("R9", 1'b0, 1'b0, 8'hB2);
        // R11: write in mid frame
        send("R11", 1'b1, 1'b0, 8'h5A);
        send("R11", 1'b0, 1'b0, 8'hC1);
        set_mode(1'b1, 2'b10);
        send("R11", 1'b0, 1'b0, 8'hC2);
        // R10
        set_mode(1'b1, 2'b11);
        send("R10", 1'b1, 1'b0, 8'h5A);
        send("R10", 1'b0, 1'b0, 8'hD1);
        send("R10", 1'b0, 1'b0, 8'hD2);
        send("R10", 1'b1, 1'b0, 8'h00);
        send("R10", 1'b0, 1'b0, 8'hD3);
        // R12: idle cycle after a delivery
        @(negedge clk);
        check("R12", {out_valid, out_addr_flag, out_new_frame, out_irq}, 4'b0000, out_data, '0);

        // random traffic
        for (int i = 0; i < 800; i++) begin
            logic isa, fe;
            logic [DATA_W-1:0] d;
            string tag;
            if (i % 40 == 0) begin
                set_mode(($urandom % 5) != 0, 2'($urandom));
            end
            isa = ($urandom % 4) == 0;
            fe  = ($urandom % 12) == 0;
            d   = (isa && ($urandom % 2)) ? own_addr : 8'($urandom);
            if (fe) tag = "R3";
            else if (!mp_enable) tag = "R2";
            else if (mp_mode == 2'b00) tag = "R4";
            else if (mp_mode == 2'b01) tag = "R5";
            else if (mp_mode == 2'b11) tag = "R10";
            else if (isa) tag = "R9";
            else tag = "R8";
            send(tag, isa, fe, d);
        end

        last_data = out_data;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule